// File: doc/BRIEF.md
# Voice Interrupt Priority Dispatcher

This block gathers pending interrupt requests from a bank of up to 31 synthesis voices. Each voice can raise two kinds of request: a wavetable loop event and a volume ramp event. A one-cycle set pulse on the matching per-voice input marks the voice as pending in its class. While anything is pending, the interrupt line to the host is held high.

The host serves these requests one at a time. It writes the select code 0x8F to the function-select register. That write starts a single scan, which picks one request in this order:

- every wavetable request before any volume ramp request;
- within a class, the voice with the smallest number.

The scan removes the chosen request from its class. It sends a one-cycle clear pulse back to that voice's control logic. It latches a status byte that names the voice and the class. The host reads that byte through the read port while 0x8F stays selected.

Each class also has a summary status bit. The bit drops only when its class has nothing left. The interrupt line falls once both summary bits are low. A global reset command clears every pending request, both summary bits and the interrupt line in one step.

Top module: `voice_irq_dispatch`

## Requirements
- R1: A select write with any code other than 0x8F neither serves nor clears a request: pending state, summary bits and interrupt line are unchanged, and the read port returns 0xFF while that code is selected.
- R2: A scan serves a pending wavetable request whenever one exists, even when lower-numbered volume ramp requests are also pending.
- R3: Within the served class, the scan picks the lowest-numbered pending voice.
- R4: The latched status byte encodes the served request as follows:
  - wavetable request for voice v: 0x60 + v (bits 7:5 = 011);
  - volume ramp request for voice v: 0x80 + v (bits 7:5 = 100);
  - nothing pending: 0xE8.
- R5: The status byte is 0xE8 after power-on reset. It changes only on a scan. The read port shows it in every cycle while the last select code written is 0x8F.
- R6: In the cycle after a scan serves voice v, exactly one bit is high across the two clear outputs: bit v of the served class. Without a serve, both clear outputs are zero. The served request is no longer pending.
- R7: A class summary bit rises with any set pulse of its class. It falls only when a serve leaves its class with no pending request.
- R8: The interrupt line is high exactly when at least one summary bit is high, and it is released when both are low.
- R9: A reset-register write with bit 0 equal to 0 clears all pending requests, both summary bits and the interrupt line, even against a set pulse in the same cycle. A write with bit 0 equal to 1 has no effect.
- R10: A set pulse in the same cycle as the serve of the same voice and class leaves that request pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wave_set | input | NUM_VOICES | Per-voice wavetable request set pulses |
| ramp_set | input | NUM_VOICES | Per-voice volume ramp request set pulses |
| sel_wr | input | 1 | Function-select write strobe |
| sel_code | input | 8 | Function-select write data |
| grst_wr | input | 1 | Reset-register write strobe |
| grst_run | input | 1 | Bit 0 of the reset-register write data (0 = reset) |
| rd_data | output | 8 | Read data for the currently selected function |
| wave_clr | output | NUM_VOICES | One-cycle clear pulse to a voice's wavetable control flag |
| ramp_clr | output | NUM_VOICES | One-cycle clear pulse to a voice's ramp control flag |
| wave_sum | output | 1 | Wavetable class summary status bit |
| ramp_sum | output | 1 | Volume ramp class summary status bit |
| irq | output | 1 | Interrupt line to the host |

## Verification
Most internal faults in this block show up at the next scan, one clock edge after the select write. Three examples:

- A pending vector that drops or keeps the wrong bit reports a wrong voice or a spurious 0xE8 in the status byte.
- A faulty priority picker reports a higher voice number, or the ramp class while wavetable work is still waiting.
- A summary register that drifts from its vector holds the interrupt line high after the last serve, or drops it too early. This is visible in the very cycle that follows the serve.

Set/serve collisions and global reset against a set pulse are both visible in the summary bit right after the edge.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam int VOICE_W = 5;
  localparam logic [7:0] SCAN_CODE  = 8'h8F;
  localparam logic [7:0] EMPTY_CODE = 8'hE8;
  localparam logic [7:0] IDLE_READ  = 8'hFF;

  typedef enum logic [1:0] {SRC_NONE, SRC_WAVE, SRC_RAMP} irq_src_e;

  // Status byte: class marker in bits 7:5, voice number below it.
  function automatic logic [7:0] encode_status(irq_src_e src, logic [VOICE_W-1:0] voice);
    case (src)
      SRC_WAVE: encode_status = {3'b011, voice};
      SRC_RAMP: encode_status = {3'b100, voice};
      default:  encode_status = EMPTY_CODE;
    endcase
  endfunction

  // All bit positions strictly below the given voice.
  function automatic logic [31:0] below_mask(logic [VOICE_W-1:0] voice);
    below_mask = (32'h1 << voice) - 32'h1;
  endfunction
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NV = 31,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic [NV-1:0] vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_class_vec.sv
module irq_class_vec #(
  parameter int NV = 31,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [NV-1:0] set_i,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [NV-1:0] vec_o
);
  logic [NV-1:0] clr_mask;

  assign clr_mask = clr_en ? (NV'(1) << clr_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_o <= '0;
    else if (flush) vec_o <= '0;
    else            vec_o <= (vec_o & ~clr_mask) | set_i;
  end

  // R10
  set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && |set_i) |=> ((vec_o & $past(set_i)) == $past(set_i)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vec_o == '0));
endmodule

// File: rtl/voice_irq_dispatch.sv
module voice_irq_dispatch
  import voice_irq_pkg::*;
#(
  parameter int NUM_VOICES = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VOICES-1:0] wave_set,
  input  logic [NUM_VOICES-1:0] ramp_set,
  input  logic                  sel_wr,
  input  logic [7:0]            sel_code,
  input  logic                  grst_wr,
  input  logic                  grst_run,
  output logic [7:0]            rd_data,
  output logic [NUM_VOICES-1:0] wave_clr,
  output logic [NUM_VOICES-1:0] ramp_clr,
  output logic                  wave_sum,
  output logic                  ramp_sum,
  output logic                  irq
);
  localparam int NV = NUM_VOICES;
  localparam int IW = (NV > 1) ? $clog2(NV) : 1;

  // Named internal events
  logic          scan_req, glob_rst, serve_wave, serve_ramp;
  logic          wave_found, ramp_found, wave_left, ramp_left;
  logic [IW-1:0] wave_idx, ramp_idx;
  logic [NV-1:0] wave_vec, ramp_vec, wave_hit, ramp_hit;
  logic          wave_sum_n, ramp_sum_n;
  irq_src_e      served_src;
  logic [IW-1:0] served_idx;
  logic [7:0]    sel_q, status_q;

  assign scan_req   = sel_wr && (sel_code == SCAN_CODE);
  assign glob_rst   = grst_wr && !grst_run;
  assign serve_wave = scan_req && wave_found;
  assign serve_ramp = scan_req && !wave_found && ramp_found;

  irq_lowest_pick #(.NV(NV)) u_wave_pick (.vec(wave_vec), .found(wave_found), .idx(wave_idx));
  irq_lowest_pick #(.NV(NV)) u_ramp_pick (.vec(ramp_vec), .found(ramp_found), .idx(ramp_idx));

  irq_class_vec #(.NV(NV)) u_wave_vec (
    .clk(clk), .rst_n(rst_n), .flush(glob_rst), .set_i(wave_set),
    .clr_en(serve_wave), .clr_idx(wave_idx), .vec_o(wave_vec));
  irq_class_vec #(.NV(NV)) u_ramp_vec (
    .clk(clk), .rst_n(rst_n), .flush(glob_rst), .set_i(ramp_set),
    .clr_en(serve_ramp), .clr_idx(ramp_idx), .vec_o(ramp_vec));

  assign wave_hit  = NV'(1) << wave_idx;
  assign ramp_hit  = NV'(1) << ramp_idx;
  assign wave_left = |(wave_vec & ~wave_hit);
  assign ramp_left = |(ramp_vec & ~ramp_hit);

  always_comb begin
    served_src = SRC_NONE;
    served_idx = '0;
    if (serve_wave) begin
      served_src = SRC_WAVE;
      served_idx = wave_idx;
    end else if (serve_ramp) begin
      served_src = SRC_RAMP;
      served_idx = ramp_idx;
    end
  end

  assign wave_sum_n = !glob_rst &&
    ((wave_sum && !(serve_wave && !wave_left)) || |wave_set);
  assign ramp_sum_n = !glob_rst &&
    ((ramp_sum && !(serve_ramp && !ramp_left)) || |ramp_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      status_q <= EMPTY_CODE;
      wave_clr <= '0;
      ramp_clr <= '0;
      wave_sum <= 1'b0;
      ramp_sum <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (sel_wr)   sel_q    <= sel_code;
      if (scan_req) status_q <= encode_status(served_src, VOICE_W'(served_idx));
      wave_clr <= serve_wave ? wave_hit : '0;
      ramp_clr <= serve_ramp ? ramp_hit : '0;
      wave_sum <= wave_sum_n;
      ramp_sum <= ramp_sum_n;
      irq      <= wave_sum_n || ramp_sum_n;
    end
  end

  assign rd_data = (sel_q == SCAN_CODE) ? status_q : IDLE_READ;

  // R2
  class_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serve_ramp |-> (wave_vec == '0));

  // R3
  wave_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serve_wave |-> ((32'(wave_vec) & below_mask(VOICE_W'(wave_idx))) == 32'h0));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_req |=> $stable(status_q));

  // R6
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wave_clr, ramp_clr}));

  // R7
  wave_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_sum == (|wave_vec));

  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (wave_sum || ramp_sum));
endmodule

// File: tb/voice_irq_dispatch_test.sv
module voice_irq_dispatch_test;
  localparam int NV = 31;

  typedef struct {
    logic [7:0]    code;
    logic [NV-1:0] wclr;
    logic [NV-1:0] rclr;
    string         tag;
  } sb_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NV-1:0] wave_set = '0, ramp_set = '0;
  logic sel_wr = 1'b0, grst_wr = 1'b0, grst_run = 1'b1;
  logic [7:0] sel_code = '0;
  logic [7:0] rd_data;
  logic [NV-1:0] wave_clr, ramp_clr;
  logic wave_sum, ramp_sum, irq;

  int checks = 0, failures = 0;
  logic [NV-1:0] m_wave = '0, m_ramp = '0;
  sb_item_t sb_q[$];
  event scan_done;

  always #4 clk = ~clk;

  voice_irq_dispatch #(.NUM_VOICES(NV)) uut (
    .clk(clk), .rst_n(rst_n), .wave_set(wave_set), .ramp_set(ramp_set),
    .sel_wr(sel_wr), .sel_code(sel_code), .grst_wr(grst_wr), .grst_run(grst_run),
    .rd_data(rd_data), .wave_clr(wave_clr), .ramp_clr(ramp_clr),
    .wave_sum(wave_sum), .ramp_sum(ramp_sum), .irq(irq));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: the class marker is added to the voice number.
  task automatic model_scan(output sb_item_t it, input logic [NV-1:0] wadd);
    it.code = 8'hE8; it.wclr = '0; it.rclr = '0;
    for (int v = 0; v < NV; v++) begin
      if (m_wave[v] && it.wclr == '0) begin
        it.code = 8'h60 + 8'(v);
        it.wclr[v] = 1'b1;
      end
    end
    if (it.wclr == '0) begin
      for (int v = 0; v < NV; v++) begin
        if (m_ramp[v] && it.rclr == '0) begin
          it.code = 8'h80 + 8'(v);
          it.rclr[v] = 1'b1;
        end
      end
    end
    m_wave = (m_wave & ~it.wclr) | wadd;
    m_ramp = m_ramp & ~it.rclr;
  endtask

  task automatic raise(logic [NV-1:0] w, logic [NV-1:0] r);
    @(negedge clk);
    wave_set = w; ramp_set = r;
    m_wave |= w; m_ramp |= r;
    @(negedge clk);
    wave_set = '0; ramp_set = '0;
  endtask

  task automatic scan(string tag, logic [NV-1:0] wadd = '0);
    sb_item_t it;
    @(negedge clk);
    sel_wr = 1'b1; sel_code = 8'h8F; wave_set = wadd;
    model_scan(it, wadd);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    sel_wr = 1'b0; wave_set = '0;
    ->scan_done;
    #0;
  endtask

  // Monitor: compares each scan result against the queued expectation.
  initial begin
    forever begin
      sb_item_t it;
      @(scan_done);
      if (sb_q.size() == 0) begin
        check("monitor empty queue", 1, 0);
      end else begin
        it = sb_q.pop_front();
        check({it.tag, " status"}, rd_data, it.code);
        check("R6 wave_clr", wave_clr, it.wclr);
        check("R6 ramp_clr", ramp_clr, it.rclr);
        check("R7 wave_sum", wave_sum, |m_wave);
        check("R7 ramp_sum", ramp_sum, |m_ramp);
        check("R8 irq", irq, (|m_wave) | (|m_ramp));
      end
    end
  end

  initial begin
    #(8 * 200000);
    check("watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 reset rd_data", rd_data, 8'hFF);
    check("R8 reset irq", irq, 0);
    scan("R4 empty");

    raise(NV'(1) << 7 | NV'(1) << 3, NV'(1) << 2);
    scan("R2 R3 wave 3 first");
    scan("R3 wave 7");
    scan("R2 ramp 2");
    scan("R4 empty after drain");

    // R1: another code changes nothing.
    raise(NV'(1) << 5, '0);
    @(negedge clk); sel_wr = 1'b1; sel_code = 8'h45;
    @(negedge clk); sel_wr = 1'b0;
    check("R1 rd_data other code", rd_data, 8'hFF);
    check("R1 wave_sum kept", wave_sum, 1);
    check("R1 irq kept", irq, 1);
    scan("R1 wave 5 still pending");

    // R5: status held across idle cycles.
    repeat (4) @(negedge clk);
    check("R5 status held", rd_data, 8'hE8 + 8'h0 - 8'h0 + 8'h65 - 8'hE8);

    // R10: set collides with serve of the same voice.
    raise(NV'(1) << 9, '0);
    scan("R10 wave 9 collide", NV'(1) << 9);
    scan("R10 wave 9 again");

    // R9: reset with bit 0 = 1 does nothing; bit 0 = 0 clears, beating a set.
    raise(NV'(1) << 4, NV'(1) << 30);
    @(negedge clk); grst_wr = 1'b1; grst_run = 1'b1;
    @(negedge clk); grst_wr = 1'b0;
    check("R9 no-op wave_sum", wave_sum, 1);
    check("R9 no-op ramp_sum", ramp_sum, 1);
    @(negedge clk); grst_wr = 1'b1; grst_run = 1'b0; wave_set = NV'(1) << 12;
    @(negedge clk); grst_wr = 1'b0; grst_run = 1'b1; wave_set = '0;
    m_wave = '0; m_ramp = '0;
    check("R9 wave_sum cleared", wave_sum, 0);
    check("R9 ramp_sum cleared", ramp_sum, 0);
    check("R9 irq low", irq, 0);
    scan("R9 empty after reset");

    // Boundary voices.
    raise(NV'(1), NV'(1) << (NV - 1));
    scan("R4 wave 0");
    scan("R4 ramp 30");
    scan("R8 drained");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule